// File: doc/BRIEF.md
# Display Frame Descriptor Fetcher

This block keeps the linked-list state for seven display fetch channels. It refreshes that state once per frame. A single-cycle `frame_start` pulse starts a pass. The pass visits the channels in ascending order. For each enabled channel, the block works out where that channel's next descriptor lives. The address comes either from a one-shot branch register or from the next-descriptor pointer kept from the previous frame. The block reads the 16-byte descriptor one word at a time over a request/valid memory port. It then stores the four words in the channel's registers.

Before any descriptor is read, its pointer is checked against a memory window given by a base address and a byte size. A pointer that fails the check leaves the channel idle for that frame. When a branch with its notify flag is taken, the block pulses a per-channel branch-status line toward an interrupt controller. Software loads next-descriptor and branch registers through a write strobe. It observes every channel through a read-back mux, which also splits the command word into its fields. The window and the enable inputs must stay stable while `busy` is high, and software writes are issued only while the engine is idle.

Top module: `frame_desc_fetch`

## Requirements
- R1: A `frame_start` pulse while idle raises `busy` at the next clock edge. `busy` stays high until the last channel of the pass has been handled, then falls. A `frame_start` pulse while `busy` is high is ignored and does not start a second pass.
- R2: Channels are handled in order 0 to 6. Every handled channel first has its source register cleared to zero. A channel whose `chan_up` bit is low issues no memory read and keeps its next-pointer, frame ID and command registers.
- R3: If bit 0 of a channel's branch register is set when the channel is handled, the descriptor pointer is the branch register's bits 31:4 with the low four bits zero. Bit 0 of the branch register is then cleared and its other bits are kept. A disabled channel keeps a pending branch.
- R4: When a branch is taken and bit 1 of the branch register is set, `bs_event` pulses for one cycle on that channel's bit. No other `bs_event` bit is raised by that channel.
- R5: With branch bit 0 clear, the descriptor pointer is the channel's stored next-descriptor register.
- R6: A pointer P is used only if P >= base and P + 16 <= base + size, computed without 32-bit wrap-around. Otherwise no read is issued and the channel keeps its next-pointer, ID and command registers, with its source at zero.
- R7: A used pointer P causes reads at P, P+4, P+8 and P+12. The returned words are stored, in that order, as next-descriptor pointer, source address, frame ID and command.
- R8: `mem_req` stays high with `mem_addr` unchanged until `mem_valid` is seen. Only one read is outstanding at a time, and `mem_req` is low whenever `busy` is low.
- R9: The read-back decodes the selected command word: `rd_len` is bits 20:2 with two zero bits appended (a byte count), `rd_eof_irq` is bit 21, `rd_sof_irq` is bit 22, and `rd_pal` is bit 26.
- R10: A software write to a next-descriptor register stores the data with bits 3:0 forced to zero.
- R11: A software write to a branch register stores the data with bits 3:2 forced to zero.
- R12: After reset all channel registers read zero, `busy` and `mem_req` are low, and `bs_event` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Single-cycle pulse that starts a descriptor pass |
| chan_up | input | NCH | Per-channel enable |
| win_base | input | 32 | First byte address of the descriptor window |
| win_size | input | 32 | Size of the descriptor window in bytes |
| nd_wr | input | 1 | Software write strobe for a next-descriptor register |
| br_wr | input | 1 | Software write strobe for a branch register |
| wr_ch | input | CW | Channel addressed by a software write |
| wr_data | input | 32 | Software write data |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_valid | input | 1 | Read data valid, completes the current request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A descriptor pass is in progress |
| bs_event | output | NCH | One-cycle branch-status pulses, one bit per channel |
| rd_ch | input | CW | Channel selected for read-back |
| rd_next | output | 32 | Next-descriptor pointer of the selected channel |
| rd_src | output | 32 | Frame source address of the selected channel |
| rd_fid | output | 32 | Frame ID of the selected channel |
| rd_cmd | output | 32 | Command word of the selected channel |
| rd_branch | output | 32 | Branch register of the selected channel |
| rd_len | output | 21 | Transfer length in bytes decoded from the command |
| rd_eof_irq | output | 1 | End-of-frame interrupt enable from the command |
| rd_sof_irq | output | 1 | Start-of-frame interrupt enable from the command |
| rd_pal | output | 1 | Palette-load flag from the command |

## Verification
The bench aims at the edges of the window check. It uses a pointer exactly 16 bytes below the window end, one exactly at the end, one just below the base, and a window that ends at the top of the 32-bit space. A 32-bit sum or an off-by-one compare would either read outside memory or skip a valid descriptor. It also covers a branch that is taken with and without the notify flag, and a pending branch on a disabled channel. A design that cleared the flag on a skipped channel, or pulsed the wrong `bs_event` bit, would show a wrong branch register or event mask. A second `frame_start` during a pass and memory latencies from zero to three cycles check that the engine neither restarts nor loses a word. Such a fault would show up as an extra read count or as misplaced descriptor fields.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int DW        = 32;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * (DW / 8);
  localparam int WIDX_W    = $clog2(DESC_WORDS);
  localparam int LEN_W     = 21;

  localparam logic [DW-1:0] ND_MASK = 32'hFFFF_FFF0;
  localparam logic [DW-1:0] BR_MASK = 32'hFFFF_FFF3;

  localparam logic [WIDX_W-1:0] W_NEXT = 2'd0;
  localparam logic [WIDX_W-1:0] W_SRC  = 2'd1;
  localparam logic [WIDX_W-1:0] W_FID  = 2'd2;
  localparam logic [WIDX_W-1:0] W_CMD  = 2'd3;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_SCAN  = 2'd1,
    FS_FETCH = 2'd2
  } fetch_state_e;

  // Whole descriptor inside [base, base+size), with one extra bit so nothing wraps.
  function automatic logic desc_in_window(input logic [DW-1:0] ptr,
                                          input logic [DW-1:0] base,
                                          input logic [DW-1:0] size);
    logic [DW:0] last_end;
    logic [DW:0] limit;
    last_end = {1'b0, ptr} + (DW+1)'(DESC_BYTES);
    limit    = {1'b0, base} + {1'b0, size};
    return (ptr >= base) && (last_end <= limit);
  endfunction

  function automatic logic [DW-1:0] branch_target(input logic [DW-1:0] br);
    return {br[DW-1:4], 4'h0};
  endfunction

  function automatic logic [LEN_W-1:0] cmd_len(input logic [DW-1:0] cmd);
    return {cmd[20:2], 2'b00};
  endfunction

  function automatic logic cmd_eof(input logic [DW-1:0] cmd);
    return cmd[21];
  endfunction

  function automatic logic cmd_sof(input logic [DW-1:0] cmd);
    return cmd[22];
  endfunction

  function automatic logic cmd_pal(input logic [DW-1:0] cmd);
    return cmd[26];
  endfunction
endpackage

// File: rtl/fdf_chan.sv
module fdf_chan
  import fdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_nd_wr,
  input  logic              sw_br_wr,
  input  logic [DW-1:0]     sw_data,
  input  logic              eng_src_clr,
  input  logic              eng_br_clr,
  input  logic              eng_we,
  input  logic [WIDX_W-1:0] eng_idx,
  input  logic [DW-1:0]     eng_word,
  output logic [DW-1:0]     next_q,
  output logic [DW-1:0]     src_q,
  output logic [DW-1:0]     fid_q,
  output logic [DW-1:0]     cmd_q,
  output logic [DW-1:0]     br_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q <= '0;
      src_q  <= '0;
      fid_q  <= '0;
      cmd_q  <= '0;
      br_q   <= '0;
    end else begin
      if (sw_nd_wr)                       next_q <= sw_data & ND_MASK;
      else if (eng_we && eng_idx == W_NEXT) next_q <= eng_word;

      if (eng_src_clr)                    src_q <= '0;
      else if (eng_we && eng_idx == W_SRC) src_q <= eng_word;

      if (eng_we && eng_idx == W_FID) fid_q <= eng_word;
      if (eng_we && eng_idx == W_CMD) cmd_q <= eng_word;

      if (sw_br_wr)        br_q    <= sw_data & BR_MASK;
      else if (eng_br_clr) br_q[0] <= 1'b0;
    end
  end

  AST_ND_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sw_nd_wr |=> next_q[3:0] == 4'h0); // R10
  AST_BR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_br_clr && !sw_br_wr |=> !br_q[0] && $stable(br_q[DW-1:1])); // R3
  AST_SRC_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_src_clr |=> src_q == '0); // R2
endmodule

// File: rtl/fdf_mem_port.sv
module fdf_mem_port
  import fdf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_rd,
  input  logic [DW-1:0] start_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  output logic          rd_done,
  output logic [DW-1:0] rd_word
);
  assign rd_done = mem_req && mem_valid;
  assign rd_word = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else if (start_rd) begin
      mem_req  <= 1'b1;
      mem_addr <= start_addr;
    end else if (rd_done) begin
      mem_req  <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |-> !start_rd); // R8
endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
  import fdf_pkg::*;
#(
  parameter int NCH = 7,
  localparam int CW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic [NCH-1:0]          chan_up,
  input  logic [DW-1:0]           win_base,
  input  logic [DW-1:0]           win_size,
  input  logic [NCH-1:0][DW-1:0]  nd_all,
  input  logic [NCH-1:0][DW-1:0]  br_all,
  input  logic                    rd_done,
  output logic                    start_rd,
  output logic [DW-1:0]           start_addr,
  output logic [NCH-1:0]          src_clr_oh,
  output logic [NCH-1:0]          br_clr_oh,
  output logic [NCH-1:0]          word_we_oh,
  output logic [WIDX_W-1:0]       word_idx,
  output logic [NCH-1:0]          bs_event,
  output logic                    busy
);
  fetch_state_e      state_q;
  logic [CW-1:0]     ch_q;
  logic [WIDX_W-1:0] widx_q;
  logic [DW-1:0]     ptr_q;
  logic [NCH-1:0]    bs_q;

  logic          in_scan, in_fetch, last_ch, up_c, take_br, ptr_ok, last_word;
  logic [DW-1:0] br_c, nd_c, sel_ptr;
  logic [NCH-1:0] ch_oh;

  assign in_scan   = (state_q == FS_SCAN);
  assign in_fetch  = (state_q == FS_FETCH);
  assign last_ch   = (ch_q == CW'(NCH-1));
  assign up_c      = chan_up[ch_q];
  assign br_c      = br_all[ch_q];
  assign nd_c      = nd_all[ch_q];
  assign take_br   = br_c[0];
  assign sel_ptr   = take_br ? branch_target(br_c) : nd_c;
  assign ptr_ok    = desc_in_window(sel_ptr, win_base, win_size);
  assign last_word = (widx_q == WIDX_W'(DESC_WORDS-1));
  assign ch_oh     = NCH'(1) << ch_q;

  assign src_clr_oh = in_scan ? ch_oh : '0;
  assign br_clr_oh  = (in_scan && up_c && take_br) ? ch_oh : '0;
  assign word_we_oh = (in_fetch && rd_done) ? ch_oh : '0;
  assign word_idx   = widx_q;
  assign bs_event   = bs_q;
  assign busy       = (state_q != FS_IDLE);

  always_comb begin
    start_rd   = 1'b0;
    start_addr = sel_ptr;
    if (in_scan && up_c && ptr_ok) begin
      start_rd = 1'b1;
    end else if (in_fetch && rd_done && !last_word) begin
      start_rd   = 1'b1;
      start_addr = ptr_q + {{(DW-WIDX_W-2){1'b0}}, widx_q + 1'b1, 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      ch_q    <= '0;
      widx_q  <= '0;
      ptr_q   <= '0;
      bs_q    <= '0;
    end else begin
      bs_q <= (in_scan && up_c && take_br && br_c[1]) ? ch_oh : '0;
      case (state_q)
        FS_IDLE: begin
          if (frame_start) begin
            state_q <= FS_SCAN;
            ch_q    <= '0;
          end
        end
        FS_SCAN: begin
          if (up_c && ptr_ok) begin
            state_q <= FS_FETCH;
            ptr_q   <= sel_ptr;
            widx_q  <= '0;
          end else if (last_ch) begin
            state_q <= FS_IDLE;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end
        FS_FETCH: begin
          if (rd_done) begin
            if (!last_word) begin
              widx_q <= widx_q + 1'b1;
            end else if (last_ch) begin
              state_q <= FS_IDLE;
            end else begin
              state_q <= FS_SCAN;
              ch_q    <= ch_q + 1'b1;
            end
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  AST_PASS_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !busy |=> busy && ch_q == '0); // R1
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && ch_q != $past(ch_q) |-> ch_q == $past(ch_q) + 1'b1); // R2
  AST_BS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bs_event)); // R4
  AST_BS_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    |bs_event |-> $past(|br_clr_oh)); // R4
endmodule

// File: rtl/frame_desc_fetch.sv
module frame_desc_fetch
  import fdf_pkg::*;
#(
  parameter int NCH = 7,
  localparam int CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [NCH-1:0]   chan_up,
  input  logic [31:0]      win_base,
  input  logic [31:0]      win_size,
  input  logic             nd_wr,
  input  logic             br_wr,
  input  logic [CW-1:0]    wr_ch,
  input  logic [31:0]      wr_data,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_valid,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic [NCH-1:0]   bs_event,
  input  logic [CW-1:0]    rd_ch,
  output logic [31:0]      rd_next,
  output logic [31:0]      rd_src,
  output logic [31:0]      rd_fid,
  output logic [31:0]      rd_cmd,
  output logic [31:0]      rd_branch,
  output logic [20:0]      rd_len,
  output logic             rd_eof_irq,
  output logic             rd_sof_irq,
  output logic             rd_pal
);
  logic [NCH-1:0][DW-1:0] nd_all, src_all, fid_all, cmd_all, br_all;
  logic [NCH-1:0]         src_clr_oh, br_clr_oh, word_we_oh;
  logic [WIDX_W-1:0]      word_idx;
  logic                   start_rd, rd_done;
  logic [DW-1:0]          start_addr, rd_word;

  fdf_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .chan_up(chan_up),
    .win_base(win_base), .win_size(win_size), .nd_all(nd_all), .br_all(br_all),
    .rd_done(rd_done), .start_rd(start_rd), .start_addr(start_addr),
    .src_clr_oh(src_clr_oh), .br_clr_oh(br_clr_oh), .word_we_oh(word_we_oh),
    .word_idx(word_idx), .bs_event(bs_event), .busy(busy)
  );

  fdf_mem_port u_port (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_addr(start_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .rd_done(rd_done), .rd_word(rd_word)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic sel_wr;
    assign sel_wr = (wr_ch == CW'(g));
    fdf_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .sw_nd_wr(nd_wr && sel_wr), .sw_br_wr(br_wr && sel_wr), .sw_data(wr_data),
      .eng_src_clr(src_clr_oh[g]), .eng_br_clr(br_clr_oh[g]),
      .eng_we(word_we_oh[g]), .eng_idx(word_idx), .eng_word(rd_word),
      .next_q(nd_all[g]), .src_q(src_all[g]), .fid_q(fid_all[g]),
      .cmd_q(cmd_all[g]), .br_q(br_all[g])
    );
  end

  logic rd_ok;
  assign rd_ok      = (rd_ch < CW'(NCH));
  assign rd_next    = rd_ok ? nd_all[rd_ch]  : '0;
  assign rd_src     = rd_ok ? src_all[rd_ch] : '0;
  assign rd_fid     = rd_ok ? fid_all[rd_ch] : '0;
  assign rd_cmd     = rd_ok ? cmd_all[rd_ch] : '0;
  assign rd_branch  = rd_ok ? br_all[rd_ch]  : '0;
  assign rd_len     = cmd_len(rd_cmd);
  assign rd_eof_irq = cmd_eof(rd_cmd);
  assign rd_sof_irq = cmd_sof(rd_cmd);
  assign rd_pal     = cmd_pal(rd_cmd);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R8
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= win_base) &&
                ({1'b0, mem_addr} + 33'd4 <= {1'b0, win_base} + {1'b0, win_size})); // R6
endmodule

// File: tb/sim_frame_desc_fetch.sv
module sim_frame_desc_fetch;
  localparam int NCH = 7;
  localparam int CW = 3;
  localparam int MEMW = 320;

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
  logic [NCH-1:0] chan_up = '0;
  logic [31:0] win_base = 32'h2000, win_size = 32'h400;
  logic nd_wr = 1'b0, br_wr = 1'b0;
  logic [CW-1:0] wr_ch = '0, rd_ch = '0;
  logic [31:0] wr_data = '0;
  logic mem_req, mem_valid;
  logic [31:0] mem_addr, mem_rdata;
  logic busy;
  logic [NCH-1:0] bs_event;
  logic [31:0] rd_next, rd_src, rd_fid, rd_cmd, rd_branch;
  logic [20:0] rd_len;
  logic rd_eof_irq, rd_sof_irq, rd_pal;

  always #2.5 clk = ~clk;

  frame_desc_fetch #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .chan_up(chan_up),
    .win_base(win_base), .win_size(win_size), .nd_wr(nd_wr), .br_wr(br_wr),
    .wr_ch(wr_ch), .wr_data(wr_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy), .bs_event(bs_event),
    .rd_ch(rd_ch), .rd_next(rd_next), .rd_src(rd_src), .rd_fid(rd_fid),
    .rd_cmd(rd_cmd), .rd_branch(rd_branch), .rd_len(rd_len),
    .rd_eof_irq(rd_eof_irq), .rd_sof_irq(rd_sof_irq), .rd_pal(rd_pal)
  );

  int n_checks = 0, n_fail = 0;
  logic [31:0] mem [MEMW];
  logic [31:0] m_nd [NCH], m_src [NCH], m_fid [NCH], m_cmd [NCH], m_br [NCH];
  int reads_seen = 0;
  logic [NCH-1:0] bs_seen = '0;
  int bs_pulses = 0;
  int wait_cnt = 0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    logic [31:0] off;
    off = a - win_base;
    if (off < 32'(MEMW * 4)) return mem[off >> 2];
    return 32'hBAD0_0000;
  endfunction

  function automatic bit b_in_win(input logic [31:0] p);
    longint unsigned e, lim;
    e = longint'(p) + 16;
    lim = longint'(win_base) + longint'(win_size);
    return (p >= win_base) && (e <= lim);
  endfunction

  // memory responder: 0..3 cycles of latency, one response per request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_rdata <= '0;
      wait_cnt  <= 0;
    end else if (mem_valid) begin
      mem_valid <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem_rd(mem_addr);
        wait_cnt  <= int'($urandom % 4);
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_valid) reads_seen <= reads_seen + 1;
    if (rst_n && (bs_event != '0)) begin
      bs_seen   <= bs_seen | bs_event;
      bs_pulses <= bs_pulses + $countones(bs_event);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_nd(input int ch, input logic [31:0] d);
    @(negedge clk);
    nd_wr = 1'b1; wr_ch = CW'(ch); wr_data = d;
    @(negedge clk);
    nd_wr = 1'b0;
    m_nd[ch] = d & 32'hFFFF_FFF0;
  endtask

  task automatic sw_br(input int ch, input logic [31:0] d);
    @(negedge clk);
    br_wr = 1'b1; wr_ch = CW'(ch); wr_data = d;
    @(negedge clk);
    br_wr = 1'b0;
    m_br[ch] = d & 32'hFFFF_FFF3;
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      rd_ch = CW'(c);
      #0.5;
      check({tag, " R7 next"}, rd_next, m_nd[c]);
      check({tag, " R2 src"}, rd_src, m_src[c]);
      check({tag, " R7 fid"}, rd_fid, m_fid[c]);
      check({tag, " R7 cmd"}, rd_cmd, m_cmd[c]);
      check({tag, " R3 branch"}, rd_branch, m_br[c]);
      check({tag, " R9 len"}, 32'(rd_len), m_cmd[c] & 32'h001F_FFFC);
      check({tag, " R9 flags"}, {29'd0, rd_pal, rd_sof_irq, rd_eof_irq},
            {29'd0, m_cmd[c][26], m_cmd[c][22], m_cmd[c][21]});
    end
  endtask

  task automatic run_frame(input string tag, input bit poke_again);
    int exp_reads = 0;
    logic [NCH-1:0] exp_bs = '0;
    logic [31:0] p;
    int guard = 0;
    for (int c = 0; c < NCH; c++) begin
      m_src[c] = '0;
      if (chan_up[c]) begin
        if (m_br[c][0]) begin
          p = {m_br[c][31:4], 4'h0};
          if (m_br[c][1]) exp_bs[c] = 1'b1;
          m_br[c][0] = 1'b0;
        end else begin
          p = m_nd[c];
        end
        if (b_in_win(p)) begin
          m_nd[c]  = mem_rd(p);
          m_src[c] = mem_rd(p + 4);
          m_fid[c] = mem_rd(p + 8);
          m_cmd[c] = mem_rd(p + 12);
          exp_reads += 4;
        end
      end
    end
    @(negedge clk);
    reads_seen = 0; bs_seen = '0; bs_pulses = 0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check({tag, " R1 busy rises"}, 32'(busy), 32'd1);
    if (poke_again) begin
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) check({tag, " R1 busy timeout"}, 32'd1, 32'd0);
    repeat (4) @(negedge clk);
    check({tag, " R1 busy low"}, 32'(busy), 32'd0);
    check({tag, " R8 req low"}, 32'(mem_req), 32'd0);
    check({tag, " R7 read count"}, 32'(reads_seen), 32'(exp_reads));
    check({tag, " R4 bs mask"}, 32'(bs_seen), 32'(exp_bs));
    check({tag, " R4 bs pulses"}, 32'(bs_pulses), 32'($countones(exp_bs)));
    check_all(tag);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < MEMW; i++) begin
      if (i % 4 == 0) mem[i] = win_base + 32'(($urandom % 80) * 16);
      else            mem[i] = $urandom;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < NCH; c++) begin
      m_nd[c] = '0; m_src[c] = '0; m_fid[c] = '0; m_cmd[c] = '0; m_br[c] = '0;
    end
    fill_mem();
    repeat (3) @(negedge clk);
    check("R12 busy reset", 32'(busy), 32'd0);
    check("R12 req reset", 32'(mem_req), 32'd0);
    check("R12 bs reset", 32'(bs_event), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R12 reset");

    // R10 / R11 write masks
    sw_nd(2, 32'h1234_567F);
    sw_br(2, 32'hABCD_EF0F);
    check_all("R10 R11 write");

    // directed boundaries in a normal window
    chan_up = 7'b101_1111;
    sw_br(2, 32'h0);
    sw_nd(0, win_base + win_size - 16);      // R6 last legal slot
    sw_nd(1, win_base + win_size);           // R6 just past the end
    sw_nd(2, win_base - 16);                 // R6 just below base
    sw_br(3, win_base | 32'h3);              // R3 R4 branch with notify
    sw_nd(3, win_base + 32'h40);
    sw_br(4, (win_base + 32'h80) | 32'h1);   // R3 branch without notify
    sw_br(5, (win_base + 32'h10) | 32'h3);   // R3 disabled channel keeps branch
    sw_nd(6, win_base);                      // R5 stored pointer
    run_frame("directed", 1'b0);

    // R1 second start during a pass is ignored
    chan_up = 7'b111_1111;
    run_frame("restart", 1'b1);

    // R6 window ending at the top of the address space
    win_base = 32'hFFFF_FC00;
    win_size = 32'h400;
    fill_mem();
    chan_up = 7'b000_0011;
    sw_nd(0, 32'hFFFF_FFF0);
    sw_nd(1, 32'hFFFF_FBF0);
    run_frame("top window", 1'b0);

    // constrained random passes
    win_base = 32'h0000_2000;
    win_size = 32'h400;
    for (int f = 0; f < 30; f++) begin
      fill_mem();
      chan_up = NCH'($urandom);
      for (int c = 0; c < NCH; c++) begin
        if ($urandom % 3 == 0)
          sw_nd(c, win_base + 32'(($urandom % 72) * 16) + 32'($urandom % 16));
        if ($urandom % 3 == 0)
          sw_br(c, win_base + 32'(($urandom % 72) * 16) + 32'($urandom % 16));
      end
      run_frame("random", ($urandom % 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule